// File: doc/BRIEF.md
# Flash ISP Command Sequencer

This block is a register-driven command engine for in-system programming of a small on-chip flash array. Software loads a command code, an address and one or two data words through a plain register port. It then writes 1 to bit 0 of the trigger register. The engine reads, programs, erases, reports identity words, moves the vector page or sums a region. When the operation is done it drops the trigger bit, so software can poll that bit. Results come back in the data register. A sticky failure flag records any operation that was refused or could not be completed.

The flash array is modelled behaviourally. An erased word reads all ones. Programming can only clear bits, so the new word is the old word ANDed with the written word. A program operation takes a fixed number of clock cycles. Erase and checksum walk the array one word per cycle.

The address space has four regions, selected by address bits [21:20]:

| Region | Base address | Writable when |
|---|---|---|
| Application | 0x000000 | application update enable is set |
| Loader | 0x100000 | loader update enable is set |
| Secure | 0x200000 | application update enable is set |
| Configuration | 0x300000 | configuration update enable is set |

The configuration region holds two words, at base and base + 4. Each region size is a parameter.

The register port has no back-pressure. A write presented with `reg_wr` high is taken at that clock edge. Read data is combinational from `reg_sel`.

Top module: `flash_isp_seq`

## Requirements
- R1: The register indices on `reg_sel` are:
  - 0 control
  - 1 command (7 bits)
  - 2 address
  - 3 data
  - 4 high data
  - 5 trigger
  - 6 status

  After reset every register reads 0. Every flash word reads 0xFFFFFFFF.
- R2: Writing 1 to trigger bit 0 while idle starts the stored command. Trigger bit 0 and status bit 0 read 1 while the command runs. Both read 0 once it completes.
- R3: Command 0x00 copies the word at the address into the data register.
- R4: Command 0x21 programs one word with the data register. Command 0x61 programs two words at the address aligned down to 8 bytes: the data register goes to the first word and the high data register to the word 4 bytes above it. In both cases the stored value is the old word AND the new one.
- R5: A program or erase is refused when the update enable of its target region is clear. The enables are control bits:
  - bit 0 application (also guards the secure region)
  - bit 1 loader
  - bit 2 configuration

  A refused operation sets the failure flag and leaves the array unchanged.
- R6: Command 0x22 sets every word of the page that contains the address to 0xFFFFFFFF. The page is `PAGE_BYTES` long and starts at the address aligned down. The erase stops at the end of the region if that comes first. Words outside that page are untouched.
- R7: The failure flag is control bit 4. Writing 1 to that bit clears it. Writing 0 to it leaves it set.
- R8: Command 0x04 returns one 32-bit word of the unique ID. The word index is the address divided by 4, and index 0, 1 or 2 is valid. An address of 12 or more sets the failure flag. Command 0x0B returns 0xDA. Command 0x0C returns `DEVICE_ID`.
- R9: Command 0x2E stores the address, aligned down to a page boundary, as the vector remap value. Status bits [31:1] show that value.
- R10: Command 0x2D sums, modulo 2^32, the words from the address onward. The byte length comes from the data register, and a partial last word is rounded up to a whole word. One word is summed per cycle. Command 0x0D then places the sum in the data register.
- R11: While a command runs, writes to the command, address, data and high data registers are ignored.
- R12: The failure flag is set by any of:
  - a command code not listed above
  - an address outside every region (including an out-of-range read)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register picked by `reg_sel` |

## Verification
The bench builds the block with:
- 64-byte pages
- a 256-byte application region
- a 128-byte loader region
- a 64-byte secure region
- four-cycle programming

These values put several things within a few hundred cycles: a page boundary inside the application region, an erase clipped by the 8-byte configuration region, an out-of-range loader address, and a checksum over the whole application region. The checksum is also long enough to hold the engine busy while writes to its operand registers are attempted.

// File: rtl/flash_isp_pkg.sv
package flash_isp_pkg;

  // Register indices on the register port.
  localparam logic [2:0] SEL_CTRL    = 3'd0;
  localparam logic [2:0] SEL_CMD     = 3'd1;
  localparam logic [2:0] SEL_ADDR    = 3'd2;
  localparam logic [2:0] SEL_DATA    = 3'd3;
  localparam logic [2:0] SEL_DATA_HI = 3'd4;
  localparam logic [2:0] SEL_TRIG    = 3'd5;
  localparam logic [2:0] SEL_STAT    = 3'd6;

  // Control register bit positions.
  localparam int CTL_APP  = 0;
  localparam int CTL_LD   = 1;
  localparam int CTL_CFG  = 2;
  localparam int CTL_FAIL = 4;

  // Command codes.
  typedef enum logic [6:0] {
    OP_READ    = 7'h00,
    OP_UID     = 7'h04,
    OP_CID     = 7'h0B,
    OP_DID     = 7'h0C,
    OP_SUM_GET = 7'h0D,
    OP_PROG32  = 7'h21,
    OP_ERASE   = 7'h22,
    OP_SUM_RUN = 7'h2D,
    OP_REMAP   = 7'h2E,
    OP_PROG64  = 7'h61
  } op_e;

  localparam logic [31:0] VENDOR_CODE = 32'h0000_00DA;

endpackage

// File: rtl/flash_isp_decode.sv
module flash_isp_decode #(
  parameter int APP_BYTES = 4096,
  parameter int LD_BYTES  = 4096,
  parameter int SP_BYTES  = 2048,
  parameter int CFG_BYTES = 8,
  parameter int IDX_W     = 12
) (
  input  logic [31:0]      addr,
  input  logic             en_app,
  input  logic             en_ld,
  input  logic             en_cfg,
  output logic             hit,
  output logic             last,
  output logic             wr_ok,
  output logic [IDX_W-1:0] idx
);
  // Word index at which each region starts in the flat array.
  localparam logic [31:0] B_LD  = 32'(APP_BYTES / 4);
  localparam logic [31:0] B_SP  = 32'((APP_BYTES + LD_BYTES) / 4);
  localparam logic [31:0] B_CFG = 32'((APP_BYTES + LD_BYTES + SP_BYTES) / 4);

  logic [31:0] size_b, base_w, off_b;

  always_comb begin
    off_b = {12'b0, addr[19:0]};
    case (addr[21:20])
      2'd0:    begin size_b = 32'(APP_BYTES); base_w = 32'd0; wr_ok = en_app; end
      2'd1:    begin size_b = 32'(LD_BYTES);  base_w = B_LD;  wr_ok = en_ld;  end
      2'd2:    begin size_b = 32'(SP_BYTES);  base_w = B_SP;  wr_ok = en_app; end
      default: begin size_b = 32'(CFG_BYTES); base_w = B_CFG; wr_ok = en_cfg; end
    endcase
    hit  = (addr[31:22] == 10'd0) && (addr[1:0] == 2'b00) && (off_b < size_b);
    last = (off_b + 32'd4) >= size_b;
    idx  = IDX_W'(base_w + (off_b >> 2));
  end

endmodule

// File: rtl/flash_isp_array.sv
module flash_isp_array #(
  parameter int WORDS = 2562,
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             erase,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (we && int'(idx) < WORDS) begin
      // Programming can only clear bits; erase returns the word to all ones.
      mem[idx] <= erase ? '1 : (mem[idx] & wdata);
    end
  end

  assign rdata = (int'(idx) < WORDS) ? mem[idx] : '0;

endmodule

// File: rtl/flash_isp_ctrl.sv
module flash_isp_ctrl
  import flash_isp_pkg::*;
#(
  parameter int          PAGE_BYTES  = 2048,
  parameter int          PROG_CYCLES = 8,
  parameter logic [31:0] DEVICE_ID   = 32'h0045_1000,
  parameter logic [95:0] UID_BITS    = 96'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [31:0] cur_addr,
  output logic        en_app,
  output logic        en_ld,
  output logic        en_cfg,
  input  logic        dec_hit,
  input  logic        dec_last,
  input  logic        dec_wr_ok,
  input  logic [31:0] arr_rdata,
  output logic        arr_we,
  output logic        arr_erase,
  output logic [31:0] arr_wdata
);
  localparam int          PG_BITS = $clog2(PAGE_BYTES);
  localparam int          CNT_W   = $clog2(PROG_CYCLES + 1);
  localparam logic [31:0] PG_MASK = 32'(PAGE_BYTES - 1);

  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  st_e              st_q;
  logic [2:0]       ctl_q;
  logic             fail_q, trig_q, half_q;
  logic [6:0]       cmd_q, op_q;
  logic [31:0]      addr_q, data_q, data_hi_q, cur_q, remap_q, sum_q, acc_q, left_q;
  logic [CNT_W-1:0] cnt_q;
  logic             step_done, step_fail, page_end, uid_bad;
  logic [31:0]      uid_word;

  assign en_app   = ctl_q[CTL_APP];
  assign en_ld    = ctl_q[CTL_LD];
  assign en_cfg   = ctl_q[CTL_CFG];
  assign cur_addr = cur_q;
  assign page_end = &cur_q[PG_BITS-1:2];
  assign uid_bad  = addr_q >= 32'd12;

  always_comb begin
    case (addr_q[3:2])
      2'd0:    uid_word = UID_BITS[31:0];
      2'd1:    uid_word = UID_BITS[63:32];
      default: uid_word = UID_BITS[95:64];
    endcase
  end

  // Per-cycle decision of the running command.
  always_comb begin
    step_done = 1'b0;
    step_fail = 1'b0;
    arr_we    = 1'b0;
    arr_erase = 1'b0;
    arr_wdata = half_q ? data_hi_q : data_q;
    if (st_q == ST_RUN) begin
      case (op_q)
        OP_READ: begin
          step_done = 1'b1;
          step_fail = !dec_hit;
        end
        OP_PROG32, OP_PROG64: begin
          if (!dec_hit || !dec_wr_ok) begin
            step_fail = 1'b1;
            step_done = 1'b1;
          end else if (cnt_q == CNT_W'(PROG_CYCLES - 1)) begin
            arr_we    = 1'b1;
            step_done = (op_q == OP_PROG32) || half_q;
          end
        end
        OP_ERASE: begin
          if (!dec_hit || !dec_wr_ok) begin
            step_fail = 1'b1;
            step_done = 1'b1;
          end else begin
            arr_we    = 1'b1;
            arr_erase = 1'b1;
            step_done = dec_last || page_end;
          end
        end
        OP_UID: begin
          step_done = 1'b1;
          step_fail = uid_bad;
        end
        OP_SUM_RUN: begin
          if (left_q == 32'd0) step_done = 1'b1;
          else if (!dec_hit) begin
            step_fail = 1'b1;
            step_done = 1'b1;
          end
        end
        OP_CID, OP_DID, OP_REMAP, OP_SUM_GET: step_done = 1'b1;
        default: begin
          step_fail = 1'b1;
          step_done = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ctl_q <= '0; fail_q <= 1'b0; trig_q <= 1'b0; half_q <= 1'b0;
      cmd_q <= '0; op_q <= '0; cnt_q <= '0;
      addr_q <= '0; data_q <= '0; data_hi_q <= '0; cur_q <= '0;
      remap_q <= '0; sum_q <= '0; acc_q <= '0; left_q <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_sel)
          SEL_CTRL:    ctl_q <= reg_wdata[2:0];
          SEL_CMD:     if (!trig_q) cmd_q <= reg_wdata[6:0];
          SEL_ADDR:    if (!trig_q) addr_q <= reg_wdata;
          SEL_DATA:    if (!trig_q) data_q <= reg_wdata;
          SEL_DATA_HI: if (!trig_q) data_hi_q <= reg_wdata;
          default: ;
        endcase
      end
      if (step_fail) fail_q <= 1'b1;
      else if (reg_wr && reg_sel == SEL_CTRL && reg_wdata[CTL_FAIL]) fail_q <= 1'b0;

      if (st_q == ST_IDLE) begin
        if (reg_wr && reg_sel == SEL_TRIG && reg_wdata[0]) begin
          st_q   <= ST_RUN;
          trig_q <= 1'b1;
          op_q   <= cmd_q;
          cnt_q  <= '0;
          half_q <= 1'b0;
          acc_q  <= '0;
          left_q <= data_q;
          if (cmd_q == OP_ERASE)       cur_q <= addr_q & ~PG_MASK;
          else if (cmd_q == OP_PROG64) cur_q <= addr_q & ~32'h7;
          else                         cur_q <= addr_q & ~32'h3;
        end
      end else begin
        if (step_done) begin
          st_q   <= ST_IDLE;
          trig_q <= 1'b0;
        end
        case (op_q)
          OP_READ:    if (dec_hit) data_q <= arr_rdata;
          OP_PROG32, OP_PROG64: begin
            if (arr_we) begin
              cnt_q <= '0;
              if (!half_q) begin
                half_q <= 1'b1;
                cur_q  <= cur_q + 32'd4;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          OP_ERASE:   cur_q <= cur_q + 32'd4;
          OP_UID:     if (!uid_bad) data_q <= uid_word;
          OP_CID:     data_q <= VENDOR_CODE;
          OP_DID:     data_q <= DEVICE_ID;
          OP_REMAP:   remap_q <= addr_q & ~PG_MASK;
          OP_SUM_GET: data_q <= sum_q;
          OP_SUM_RUN: begin
            if (left_q == 32'd0) sum_q <= acc_q;
            else if (dec_hit) begin
              acc_q  <= acc_q + arr_rdata;
              cur_q  <= cur_q + 32'd4;
              left_q <= (left_q > 32'd4) ? left_q - 32'd4 : 32'd0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CTRL:    reg_rdata = {27'b0, fail_q, 1'b0, ctl_q};
      SEL_CMD:     reg_rdata = {25'b0, cmd_q};
      SEL_ADDR:    reg_rdata = addr_q;
      SEL_DATA:    reg_rdata = data_q;
      SEL_DATA_HI: reg_rdata = data_hi_q;
      SEL_TRIG:    reg_rdata = {31'b0, trig_q};
      SEL_STAT:    reg_rdata = remap_q | {31'b0, trig_q};
      default:     reg_rdata = '0;
    endcase
  end

  // R2: the trigger bit is high exactly while the sequencer is running.
  a_r2_trig_while_run: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q == (st_q == ST_RUN));

  // R11: an address write during a command leaves the operand untouched.
  a_r11_busy_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q && reg_wr && reg_sel == SEL_ADDR) |=> $stable(addr_q));

  // R7: the failure flag only drops on a write of one to its bit.
  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !(reg_wr && reg_sel == SEL_CTRL && reg_wdata[CTL_FAIL])) |=> fail_q);

  // R5: the array is only written inside a region that is open for update.
  a_r5_write_permitted: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (dec_hit && dec_wr_ok));

  // R9: the remap value never carries bits below the page size.
  a_r9_remap_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (remap_q & PG_MASK) == 32'd0);

endmodule

// File: rtl/flash_isp_seq.sv
module flash_isp_seq #(
  parameter int          PAGE_BYTES  = 2048,
  parameter int          APP_BYTES   = 4096,
  parameter int          LD_BYTES    = 4096,
  parameter int          SP_BYTES    = 2048,
  parameter int          CFG_BYTES   = 8,
  parameter int          PROG_CYCLES = 8,
  parameter logic [31:0] DEVICE_ID   = 32'h0045_1000,
  parameter logic [95:0] UID_BITS    = 96'h0000_0003_0000_0002_0000_0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int WORDS = (APP_BYTES + LD_BYTES + SP_BYTES + CFG_BYTES) / 4;
  localparam int IDX_W = $clog2(WORDS);

  logic [31:0]      cur_addr, arr_rdata, arr_wdata;
  logic             en_app, en_ld, en_cfg;
  logic             dec_hit, dec_last, dec_wr_ok;
  logic             arr_we, arr_erase;
  logic [IDX_W-1:0] idx;

  flash_isp_ctrl #(
    .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES),
    .DEVICE_ID(DEVICE_ID), .UID_BITS(UID_BITS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cur_addr(cur_addr), .en_app(en_app), .en_ld(en_ld), .en_cfg(en_cfg),
    .dec_hit(dec_hit), .dec_last(dec_last), .dec_wr_ok(dec_wr_ok),
    .arr_rdata(arr_rdata), .arr_we(arr_we), .arr_erase(arr_erase), .arr_wdata(arr_wdata)
  );

  flash_isp_decode #(
    .APP_BYTES(APP_BYTES), .LD_BYTES(LD_BYTES), .SP_BYTES(SP_BYTES),
    .CFG_BYTES(CFG_BYTES), .IDX_W(IDX_W)
  ) u_decode (
    .addr(cur_addr), .en_app(en_app), .en_ld(en_ld), .en_cfg(en_cfg),
    .hit(dec_hit), .last(dec_last), .wr_ok(dec_wr_ok), .idx(idx)
  );

  flash_isp_array #(.WORDS(WORDS), .IDX_W(IDX_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .erase(arr_erase),
    .idx(idx), .wdata(arr_wdata), .rdata(arr_rdata)
  );

endmodule

// File: tb/flash_isp_seq_tb.sv
`timescale 1ns/1ps
module flash_isp_seq_tb;
  localparam logic [95:0] UIDV = 96'hC0DE0003_BEEF0002_F00D0001;
  localparam logic [31:0] DIDV = 32'h0045_1A00;
  localparam logic [2:0] S_CTRL = 3'd0, S_CMD = 3'd1, S_ADDR = 3'd2, S_DATA = 3'd3,
                         S_DHI = 3'd4, S_TRIG = 3'd5, S_STAT = 3'd6;

  logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, rd_own = 1'b0;
  logic [2:0]  drv_sel = 3'd0, mon_sel = 3'd0, reg_sel;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int n_vec = 0, n_bad = 0, pending = 0;

  typedef struct { logic [2:0] sel; logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];

  assign reg_sel = rd_own ? mon_sel : drv_sel;
  always #10 clk = ~clk;

  flash_isp_seq #(
    .PAGE_BYTES(64), .APP_BYTES(256), .LD_BYTES(128), .SP_BYTES(64), .CFG_BYTES(8),
    .PROG_CYCLES(4), .DEVICE_ID(DIDV), .UID_BITS(UIDV)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // Monitor: pops the expected item and compares it against the register.
  initial begin
    forever begin
      item_t it;
      wait (pending != 0);
      it = sbq.pop_front();
      @(negedge clk);
      rd_own = 1'b1; mon_sel = it.sel;
      #1;
      n_vec++;
      if (reg_rdata !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, reg_rdata, it.exp);
      end
      rd_own = 1'b0;
      pending--;
    end
  end

  task automatic expect_reg(input logic [2:0] s, input logic [31:0] e, input string tag);
    item_t it;
    it.sel = s; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    pending++;
    wait (pending == 0);
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; drv_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    bit done = 1'b0;
    for (int i = 0; i < 5000 && !done; i++) begin
      @(negedge clk);
      drv_sel = S_TRIG;
      #1;
      if (reg_rdata[0] == 1'b0) done = 1'b1;
    end
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL R2: actual trigger stuck at 1, expected 0");
    end
  endtask

  task automatic run(input logic [6:0] c, input logic [31:0] a, input logic [31:0] d);
    wr(S_CMD, {25'b0, c});
    wr(S_ADDR, a);
    wr(S_DATA, d);
    wr(S_TRIG, 32'd1);
    wait_idle();
  endtask

  task automatic rd_flash(input logic [31:0] a, input logic [31:0] e, input string tag);
    run(7'h00, a, 32'd0);
    expect_reg(S_DATA, e, tag);
  endtask

  initial begin
    #2_000_000;
    n_vec++; n_bad++;
    $display("FAIL R2 watchdog: actual run still active, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_reg(S_CTRL, 32'h0, "R1 ctrl reset");
    expect_reg(S_TRIG, 32'h0, "R2 trig reset");
    expect_reg(S_STAT, 32'h0, "R1 stat reset");
    expect_reg(S_DATA, 32'h0, "R1 data reset");
    rd_flash(32'h10, 32'hFFFF_FFFF, "R1 erased word / R3 read");

    // R5 program without enable
    run(7'h21, 32'h10, 32'h1234_5678);
    expect_reg(S_CTRL, 32'h10, "R5 refused program sets fail");
    rd_flash(32'h10, 32'hFFFF_FFFF, "R5 refused program leaves word");

    // R7 write-one-to-clear
    wr(S_CTRL, 32'h01);
    expect_reg(S_CTRL, 32'h11, "R7 zero write keeps fail");
    wr(S_CTRL, 32'h11);
    expect_reg(S_CTRL, 32'h01, "R7 one write clears fail");

    // R4 program with AND behaviour
    run(7'h21, 32'h10, 32'h1234_5678);
    rd_flash(32'h10, 32'h1234_5678, "R4 program word");
    run(7'h21, 32'h10, 32'hFF00_FF00);
    rd_flash(32'h10, 32'h1200_5600, "R4 program only clears bits");
    run(7'h21, 32'h40, 32'h1111_0000);
    wr(S_DHI, 32'h0F0F_0F0F);
    run(7'h61, 32'h24, 32'hAAAA_5555);
    rd_flash(32'h20, 32'hAAAA_5555, "R4 double program low word");
    rd_flash(32'h24, 32'h0F0F_0F0F, "R4 double program high word");

    // R6 page erase
    run(7'h22, 32'h14, 32'h0);
    rd_flash(32'h10, 32'hFFFF_FFFF, "R6 erased in page");
    rd_flash(32'h24, 32'hFFFF_FFFF, "R6 erased in page upper");
    rd_flash(32'h40, 32'h1111_0000, "R6 next page untouched");
    expect_reg(S_CTRL, 32'h01, "R6 erase no fail");

    // R5 loader region
    run(7'h21, 32'h10_0008, 32'hCAFE_F00D);
    expect_reg(S_CTRL, 32'h11, "R5 loader locked");
    wr(S_CTRL, 32'h13);
    expect_reg(S_CTRL, 32'h03, "R7 clear with enables");
    run(7'h21, 32'h10_0008, 32'hCAFE_F00D);
    rd_flash(32'h10_0008, 32'hCAFE_F00D, "R5 loader open");

    // R5/R6 configuration region
    wr(S_CTRL, 32'h07);
    run(7'h21, 32'h30_0004, 32'h5A5A_0000);
    rd_flash(32'h30_0004, 32'h5A5A_0000, "R5 config open");
    run(7'h22, 32'h30_0004, 32'h0);
    rd_flash(32'h30_0000, 32'hFFFF_FFFF, "R6 config erase word0");
    rd_flash(32'h30_0004, 32'hFFFF_FFFF, "R6 config erase word1");
    expect_reg(S_CTRL, 32'h07, "R6 region-end erase no fail");

    // R8 identity
    run(7'h04, 32'h4, 32'h0);
    expect_reg(S_DATA, 32'hBEEF_0002, "R8 unique id word1");
    run(7'h04, 32'hC, 32'h0);
    expect_reg(S_CTRL, 32'h17, "R8 unique id index 3 fails");
    wr(S_CTRL, 32'h17);
    run(7'h0B, 32'h0, 32'h0);
    expect_reg(S_DATA, 32'h0000_00DA, "R8 company id");
    run(7'h0C, 32'h4, 32'h0);
    expect_reg(S_DATA, DIDV, "R8 device id");

    // R9 remap
    run(7'h2E, 32'h1C7, 32'h0);
    expect_reg(S_STAT, 32'h1C0, "R9 remap aligned");

    // R10 checksum
    run(7'h2D, 32'h40, 32'd12);
    run(7'h0D, 32'h0, 32'h0);
    expect_reg(S_DATA, 32'h1110_FFFE, "R10 checksum three words");
    run(7'h2D, 32'h40, 32'd6);
    run(7'h0D, 32'h0, 32'h0);
    expect_reg(S_DATA, 32'h1110_FFFF, "R10 checksum partial word");

    // R11 busy ignore, R2 busy visible
    wr(S_CMD, 32'h2D);
    wr(S_ADDR, 32'h0);
    wr(S_DATA, 32'd256);
    wr(S_TRIG, 32'd1);
    expect_reg(S_TRIG, 32'h1, "R2 trigger high while busy");
    expect_reg(S_STAT, 32'h1C1, "R2 status busy bit");
    wr(S_ADDR, 32'hDEAD);
    wr(S_DATA, 32'h7);
    wr(S_CMD, 32'h0);
    wr(S_DHI, 32'h0);
    wait_idle();
    expect_reg(S_ADDR, 32'h0, "R11 address held");
    expect_reg(S_DATA, 32'd256, "R11 data held");
    expect_reg(S_CMD, 32'h2D, "R11 command held");
    expect_reg(S_DHI, 32'h0F0F_0F0F, "R11 high data held");
    expect_reg(S_TRIG, 32'h0, "R2 trigger cleared");

    // R12 failures
    expect_reg(S_CTRL, 32'h07, "R12 clean before");
    run(7'h3F, 32'h0, 32'h0);
    expect_reg(S_CTRL, 32'h17, "R12 unknown code fails");
    wr(S_CTRL, 32'h17);
    run(7'h00, 32'h10_0100, 32'h0);
    expect_reg(S_CTRL, 32'h17, "R12 out-of-range read fails");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule